// File: doc/BRIEF.md
# Per-Port Ingress Rate Limiter

This block polices the receive traffic of one switch port. Every received frame is presented once, at its end, as a single descriptor: its length in bytes, its priority (0 to 3) and its destination class. The block keeps one signed token bucket for each priority. A periodic refill pulse adds a rate-dependent amount to each bucket, up to a fixed ceiling. Each frame that falls in the selected class is charged against the bucket of its priority. The block then returns a verdict: either the frame passes, or it is flagged for drop.

A configuration bit chooses between two actions for a frame that arrives while its bucket is exhausted. The frame can be flagged for drop. The other choice is to let it through and raise a pause request instead. All configuration comes in on plain register inputs.

Frame descriptors arrive on a valid/ready stream, and verdicts leave on another one. A descriptor is accepted on a clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` is high whenever no verdict is waiting, or when the waiting verdict is consumed in that same cycle. A verdict stays valid and unchanged until `res_ready` is high. The refill pulse and the configuration inputs have no handshake.

Top module: `ingress_rate_limiter`

## Requirements
- R1: `frm_ready` equals `!res_valid || res_ready`. A descriptor accepted at a clock edge raises `res_valid` with its verdict at that same edge. `res_valid` and `res_drop` then hold until a cycle in which `res_ready` is high.
- R2: When `cfg_pkt_mode`=0, a frame's charge is 8 times its byte count. Each refill pulse adds `code*BIT_STEP` to the bucket, with BIT_STEP=64 by default.
- R3: When `cfg_pkt_mode`=1, every charged frame costs 1. Each refill pulse adds `code`.
- R4: Each accepted eligible frame is checked against its priority's bucket. If the bucket is zero or negative, the limit action applies and the bucket is not charged. Otherwise the full charge is subtracted, and the bucket may go negative.
- R5: `frm_class` is encoded as 0 = known unicast, 1 = flooded unicast, 2 = multicast, 3 = broadcast. `cfg_class_sel` chooses which frames are eligible: 0 = all frames, 1 = classes 1 to 3, 2 = classes 2 and 3, 3 = class 3 only. A frame that is not eligible passes and is not charged.
- R6: When `cfg_cnt_ifg`=1, 12 bytes are added to the byte count before the bit charge is formed.
- R7: When `cfg_cnt_pre`=1, 8 bytes are added to the byte count before the bit charge is formed.
- R8: A priority whose 7-bit code is zero is unlimited. Its frames are never dropped, never charged, and never keep the pause request high. The code of priority p sits in `cfg_limit_code[7p+6:7p]`.
- R9: After a refill pulse, a bucket holds at most BIT_CEIL (16384) in bit mode and at most PKT_CEIL (16) in packet mode.
- R10: When `cfg_fc_en`=0, the limit action sets `res_drop`=1 and `pause_req` stays 0. When `cfg_fc_en`=1, the limit action sets `res_drop`=0 and raises `pause_req` at the same edge.
- R11: Once raised, `pause_req` stays high until every limited priority's bucket is positive. It falls on the edge after that condition is first seen. Clearing `cfg_fc_en` also lowers it.
- R12: After reset, every bucket is 0 and `res_valid`=0, `res_drop`=0 and `pause_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refill_tick | input | 1 | One-cycle pulse that refills every bucket |
| cfg_pkt_mode | input | 1 | 1 = count packets, 0 = count bits |
| cfg_fc_en | input | 1 | 1 = pause instead of dropping |
| cfg_class_sel | input | 2 | Eligible class selection |
| cfg_cnt_ifg | input | 1 | Add inter-frame-gap bytes to the charge |
| cfg_cnt_pre | input | 1 | Add preamble bytes to the charge |
| cfg_limit_code | input | 28 | Four 7-bit rate codes, priority 0 in the low bits |
| frm_valid | input | 1 | End-of-frame descriptor valid |
| frm_ready | output | 1 | Descriptor can be accepted |
| frm_len | input | 14 | Frame length in bytes |
| frm_prio | input | 2 | Frame priority |
| frm_class | input | 2 | Destination class |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict consumed |
| res_drop | output | 1 | 1 = drop the frame |
| pause_req | output | 1 | Flow-control request |

## Verification
A bucket that holds a wrong value shows up at the ports only through later verdicts. The error becomes visible the first time the true level and the corrupted level lie on opposite sides of zero. The stimulus is therefore built so that each charge, refill and overhead choice decides the verdict of the very next frame. A charge missed on a frame outside the selected class, a wrong overhead byte count, or a refill that was not clipped at the ceiling each turn a pass into a drop, or a drop into a pass, within one or two descriptors. A wrong pause state is visible on `pause_req` one edge after the bucket condition changes.

// File: rtl/irl_pkg.sv
`timescale 1ns/1ps
package irl_pkg;
  typedef enum logic [1:0] {
    CLS_UCAST_KNOWN = 2'd0,
    CLS_UCAST_FLOOD = 2'd1,
    CLS_MCAST       = 2'd2,
    CLS_BCAST       = 2'd3
  } frm_class_e;

  localparam int IFG_BYTES = 12;
  localparam int PRE_BYTES = 8;
endpackage

// File: rtl/irl_class_filter.sv
`timescale 1ns/1ps
module irl_class_filter
  import irl_pkg::*;
(
  input  frm_class_e cls,
  input  logic [1:0] sel,
  output logic       eligible
);
  always_comb begin
    unique case (sel)
      2'd0:    eligible = 1'b1;
      2'd1:    eligible = (cls != CLS_UCAST_KNOWN);
      2'd2:    eligible = (cls == CLS_MCAST) || (cls == CLS_BCAST);
      default: eligible = (cls == CLS_BCAST);
    endcase
  end
endmodule

// File: rtl/irl_cost.sv
`timescale 1ns/1ps
module irl_cost
  import irl_pkg::*;
#(
  parameter int LEN_W = 14,
  localparam int CHG_W = LEN_W + 4
) (
  input  logic [LEN_W-1:0] len,
  input  logic             pkt_mode,
  input  logic             cnt_ifg,
  input  logic             cnt_pre,
  output logic [CHG_W-1:0] charge
);
  localparam int BYTE_W = LEN_W + 1;
  logic [BYTE_W-1:0] bytes;

  always_comb begin
    bytes = BYTE_W'(len);
    if (cnt_ifg) bytes = bytes + BYTE_W'(IFG_BYTES);
    if (cnt_pre) bytes = bytes + BYTE_W'(PRE_BYTES);
    charge = pkt_mode ? CHG_W'(1) : {bytes, 3'b000};
  end
endmodule

// File: rtl/irl_bucket.sv
`timescale 1ns/1ps
module irl_bucket #(
  parameter int BKT_W    = 24,
  parameter int CODE_W   = 7,
  parameter int CHG_W    = 18,
  parameter int BIT_STEP = 64,
  parameter int BIT_CEIL = 16384,
  parameter int PKT_CEIL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pkt_mode,
  input  logic [CODE_W-1:0] code,
  input  logic              hit,
  input  logic [CHG_W-1:0]  charge,
  output logic              ok,
  output logic              over
);
  localparam int EXT_W = BKT_W + 2;

  logic signed [BKT_W-1:0] level;
  logic signed [EXT_W-1:0] refill_x, charge_x, ceil_x, nxt;
  logic unlimited, positive;

  assign unlimited = (code == '0);
  assign positive  = !level[BKT_W-1] && (level != '0);
  assign ok        = unlimited || positive;
  assign over      = !unlimited && !positive;

  always_comb begin
    refill_x = pkt_mode ? $signed(EXT_W'(code))
                        : $signed(EXT_W'(code) * EXT_W'(BIT_STEP));
    charge_x = $signed(EXT_W'(charge));
    ceil_x   = pkt_mode ? $signed(EXT_W'(PKT_CEIL)) : $signed(EXT_W'(BIT_CEIL));
    nxt      = EXT_W'(level);
    if (tick) nxt = nxt + refill_x;
    if (hit && !unlimited && positive) nxt = nxt - charge_x;
    if (nxt > ceil_x) nxt = ceil_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= $signed(nxt[BKT_W-1:0]);
  end

  p_no_charge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !tick && !ok) |=> $stable(level));

  p_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (level <= $past(ceil_x)));
endmodule

// File: rtl/ingress_rate_limiter.sv
`timescale 1ns/1ps
module ingress_rate_limiter
  import irl_pkg::*;
#(
  parameter int NPRIO    = 4,
  parameter int CODE_W   = 7,
  parameter int LEN_W    = 14,
  parameter int BKT_W    = 24,
  parameter int BIT_STEP = 64,
  parameter int BIT_CEIL = 16384,
  parameter int PKT_CEIL = 16,
  localparam int PRIO_W  = $clog2(NPRIO),
  localparam int CHG_W   = LEN_W + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    refill_tick,
  input  logic                    cfg_pkt_mode,
  input  logic                    cfg_fc_en,
  input  logic [1:0]              cfg_class_sel,
  input  logic                    cfg_cnt_ifg,
  input  logic                    cfg_cnt_pre,
  input  logic [NPRIO*CODE_W-1:0] cfg_limit_code,
  input  logic                    frm_valid,
  output logic                    frm_ready,
  input  logic [LEN_W-1:0]        frm_len,
  input  logic [PRIO_W-1:0]       frm_prio,
  input  logic [1:0]              frm_class,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic                    res_drop,
  output logic                    pause_req
);
  logic             accept, eligible, limit_evt;
  logic [CHG_W-1:0] charge;
  logic [NPRIO-1:0] hit, ok, over;
  frm_class_e       cls;

  assign frm_ready = !res_valid || res_ready;
  assign accept    = frm_valid && frm_ready;
  assign cls       = frm_class_e'(frm_class);

  irl_class_filter u_filter (
    .cls      (cls),
    .sel      (cfg_class_sel),
    .eligible (eligible)
  );

  irl_cost #(.LEN_W(LEN_W)) u_cost (
    .len      (frm_len),
    .pkt_mode (cfg_pkt_mode),
    .cnt_ifg  (cfg_cnt_ifg),
    .cnt_pre  (cfg_cnt_pre),
    .charge   (charge)
  );

  for (genvar p = 0; p < NPRIO; p++) begin : g_prio
    assign hit[p] = accept && eligible && (frm_prio == PRIO_W'(p));
    irl_bucket #(
      .BKT_W(BKT_W), .CODE_W(CODE_W), .CHG_W(CHG_W),
      .BIT_STEP(BIT_STEP), .BIT_CEIL(BIT_CEIL), .PKT_CEIL(PKT_CEIL)
    ) u_bkt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (refill_tick),
      .pkt_mode (cfg_pkt_mode),
      .code     (cfg_limit_code[p*CODE_W +: CODE_W]),
      .hit      (hit[p]),
      .charge   (charge),
      .ok       (ok[p]),
      .over     (over[p])
    );
  end

  assign limit_evt = accept && eligible && !ok[frm_prio];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_drop  <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_drop  <= limit_evt && !cfg_fc_en;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pause_req <= 1'b0;
    else if (!cfg_fc_en) pause_req <= 1'b0;
    else if (limit_evt)  pause_req <= 1'b1;
    else if (over == '0) pause_req <= 1'b0;
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_drop)));

  p_fc_no_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_fc_en) |=> !res_drop);

  p_unlimited_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_limit_code[frm_prio*CODE_W +: CODE_W] == '0) |=> !res_drop);

  p_pause_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && cfg_fc_en && (over != '0)) |=> pause_req);
endmodule

// File: tb/sim_ingress_rate_limiter.sv
`timescale 1ns/1ps
module sim_ingress_rate_limiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refill_tick = 1'b0;
  logic        cfg_pkt_mode = 1'b0, cfg_fc_en = 1'b0, cfg_cnt_ifg = 1'b0, cfg_cnt_pre = 1'b0;
  logic [1:0]  cfg_class_sel = 2'd0;
  logic [27:0] cfg_limit_code = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [13:0] frm_len = '0;
  logic [1:0]  frm_prio = '0;
  logic [1:0]  frm_class = '0;
  logic        res_valid, res_drop, pause_req;
  logic        res_ready = 1'b1;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ingress_rate_limiter u0 (
    .clk(clk), .rst_n(rst_n), .refill_tick(refill_tick),
    .cfg_pkt_mode(cfg_pkt_mode), .cfg_fc_en(cfg_fc_en), .cfg_class_sel(cfg_class_sel),
    .cfg_cnt_ifg(cfg_cnt_ifg), .cfg_cnt_pre(cfg_cnt_pre), .cfg_limit_code(cfg_limit_code),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_len(frm_len), .frm_prio(frm_prio),
    .frm_class(frm_class), .res_valid(res_valid), .res_ready(res_ready),
    .res_drop(res_drop), .pause_req(pause_req)
  );

  // {ticks[31:24], len[23:10], prio[9:8], class[7:6], 5'b0, exp_drop[0]}
  // Bit mode, only priority 0 limited (code 1 = 64 bits per refill).
  localparam logic [31:0] VEC [7] = '{
    {8'd0, 14'd10, 2'd0, 2'd3, 5'd0, 1'b1},  // R12/R4: bucket 0 after reset
    {8'd2, 14'd10, 2'd0, 2'd3, 5'd0, 1'b0},  // R2: 128 - 80 = 48
    {8'd0, 14'd10, 2'd0, 2'd0, 5'd0, 1'b0},  // R4: 48 > 0, goes to -32
    {8'd0, 14'd10, 2'd0, 2'd0, 5'd0, 1'b1},  // R4: negative bucket
    {8'd0, 14'd10, 2'd1, 2'd0, 5'd0, 1'b0},  // R8: code 0 unlimited
    {8'd1, 14'd4,  2'd0, 2'd2, 5'd0, 1'b0},  // R2: -32 + 64 = 32, to 0
    {8'd0, 14'd1,  2'd0, 2'd1, 5'd0, 1'b1}   // R4: zero is not positive
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) refill_tick = 1'b1;
      @(posedge clk);
      @(negedge clk) refill_tick = 1'b0;
    end
  endtask

  task automatic send(input int len, input int prio, input int cls);
    @(negedge clk);
    frm_len = 14'(len); frm_prio = 2'(prio); frm_class = 2'(cls); frm_valid = 1'b1;
    @(posedge clk);
    @(negedge clk) frm_valid = 1'b0;
  endtask

  task automatic send_chk(input int len, input int prio, input int cls,
                          input int exp_drop, input string req);
    send(len, prio, cls);
    chk(req, int'(res_drop), exp_drop);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R12 res_valid", int'(res_valid), 0);
    chk("R12 pause_req", int'(pause_req), 0);
    chk("R1 frm_ready idle", int'(frm_ready), 1);

    cfg_limit_code = {7'd0, 7'd0, 7'd0, 7'd1};
    for (int v = 0; v < 7; v++) begin
      tick_n(int'(VEC[v][31:24]));
      send(int'(VEC[v][23:10]), int'(VEC[v][9:8]), int'(VEC[v][7:6]));
      chk("R1 res_valid", int'(res_valid), 1);
      chk("R2/R4 verdict", int'(res_drop), int'(VEC[v][0]));
      chk("R10 no pause when disabled", int'(pause_req), 0);
    end

    // R5: broadcast only; multicast is not charged (bucket 0 -> 64)
    cfg_class_sel = 2'd3;
    tick_n(1);
    send_chk(100, 0, 2, 0, "R5 multicast passes");
    send_chk(1, 0, 3, 0, "R5 multicast not charged");   // 64 - 8 = 56

    // R6/R7: both overheads, 56 - 168 = -112, +64 = -48
    cfg_class_sel = 2'd0; cfg_cnt_ifg = 1'b1; cfg_cnt_pre = 1'b1;
    send_chk(1, 0, 0, 0, "R6 overhead frame passes");
    tick_n(1);
    send_chk(1, 0, 0, 1, "R6 R7 overhead charged");
    // R7 alone: -48 + 64 = 16, 16 - 72 = -56
    cfg_cnt_ifg = 1'b0;
    tick_n(1);
    send_chk(1, 0, 0, 0, "R7 preamble frame passes");
    send_chk(1, 0, 0, 1, "R7 preamble charged");
    // R6 alone: -56 + 128 = 72, 72 - 104 = -32
    cfg_cnt_ifg = 1'b1; cfg_cnt_pre = 1'b0;
    tick_n(2);
    send_chk(1, 0, 0, 0, "R6 gap frame passes");
    send_chk(1, 0, 0, 1, "R6 gap charged");

    // R3: packet mode, priority 2 code 2
    cfg_cnt_ifg = 1'b0; cfg_pkt_mode = 1'b1;
    cfg_limit_code = {7'd0, 7'd2, 7'd0, 7'd1};
    tick_n(1);
    send_chk(1000, 2, 0, 0, "R3 first packet");
    send_chk(1000, 2, 0, 0, "R3 second packet");
    send_chk(1000, 2, 0, 1, "R3 budget exhausted");

    // R9: 20 refills saturate at 16
    tick_n(20);
    for (int k = 0; k < 16; k++) send_chk(1, 2, 0, 0, "R9 within ceiling");
    send_chk(1, 2, 0, 1, "R9 ceiling clipped");

    // R10/R11: flow control, only priority 2 limited, bucket at 0
    cfg_limit_code = {7'd0, 7'd2, 7'd0, 7'd0};
    cfg_fc_en = 1'b1;
    send_chk(1, 2, 0, 0, "R10 fc no drop");
    chk("R10 pause raised", int'(pause_req), 1);
    send_chk(1, 1, 0, 0, "R8 unlimited under fc");
    chk("R11 pause held", int'(pause_req), 1);
    tick_n(1);
    @(posedge clk); @(negedge clk);
    chk("R11 pause released", int'(pause_req), 0);

    // R1: back-pressure on the verdict stream
    cfg_fc_en = 1'b0;
    res_ready = 1'b0;
    send(1, 1, 0);
    chk("R1 verdict valid", int'(res_valid), 1);
    chk("R1 frm_ready low", int'(frm_ready), 0);
    repeat (2) @(negedge clk);
    chk("R1 verdict held", int'(res_valid), 1);
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 verdict consumed", int'(res_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule